// File: doc/BRIEF.md
# I2C Register Access Sequencer

This block converts one user request into the ordered list of byte-level commands needed to write a single register or read a single register on an I2C slave device. It sits above a byte engine that produces the serial clock and data waveforms. The sequencer sends that engine one command at a time. Each command carries an action (send a byte, receive a byte, or none), a START qualifier, a STOP qualifier, a master-acknowledge level and a data byte. The sequencer then waits for the engine to report completion together with the slave's acknowledge status.

The controller is a Moore machine. Every command step has an issue state, which drives the command strobe for exactly one cycle, and a wait state, which holds the same command attributes until the completion pulse arrives. The states and transitions are as follows:

- IDLE goes to SA_ISS on an accepted request.
- SA_ISS/SA_WT send the address byte with direction 0 and START.
- RA_ISS/RA_WT send the register address.
- On a write, WD_ISS/WD_WT send the data byte with STOP.
- On a read, RS_ISS/RS_WT send the address byte with direction 1 and a repeated START. RX_ISS/RX_WT then receive one byte with STOP and master not-acknowledge.
- A not-acknowledge on any send step diverts to AB_ISS/AB_WT, which issue a STOP-only command.
- FIN_OK and FIN_ERR each last one cycle and then return to IDLE.

Top module: `i2c_reg_seq`

## Requirements
- R1: After reset the block is idle: busy_o, done_o, err_o and cmd_vld_o are 0, and rd_data_o is 0x00.
- R2: A write request (rnw_i=0) issues three commands with cmd_act_o=2'b01 (send), in this order: {slave address, 1'b0} with START; the register address; the write byte with STOP.
- R3: A read request (rnw_i=1) issues four commands in this order. The first three are sends: {slave address, 1'b0} with START; the register address; {slave address, 1'b1} with START. The fourth is a receive (cmd_act_o=2'b10) with STOP and cmd_mnack_o=1. cmd_mnack_o is 1 only on a receive command.
- R4: Each command is a single-cycle cmd_vld_o strobe. No further command is issued until cmd_done_i has acknowledged the previous one.
- R5: If cmd_done_i arrives with cmd_nack_i=1 on any send step, the next command is STOP-only: cmd_act_o=2'b00, stop=1, start=0. Its completion ends the transaction with err_o=1.
- R6: done_o is a one-cycle pulse at the end of every accepted transaction. err_o is high only together with done_o.
- R7: busy_o rises in the cycle after the request is accepted, stays high through the done_o cycle, and is low in the cycle after it.
- R8: A request asserted while busy_o is high is ignored. The commands of the running transaction keep the operands latched at acceptance, and no new transaction starts afterwards.
- R9: rd_data_o loads cmd_rd_data_i when the receive step completes, and holds its value at all other times, including across write and aborted transactions.
- R10: All command outputs stay constant while the sequencer is waiting for a completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe, accepted only when idle |
| rnw_i | input | 1 | 1 = register read, 0 = register write |
| slv_addr_i | input | 7 | Slave device address |
| reg_addr_i | input | 8 | Register address inside the slave |
| wr_data_i | input | 8 | Byte to write |
| done_o | output | 1 | Transaction finished (one cycle) |
| err_o | output | 1 | Transaction aborted on a not-acknowledge, valid with done_o |
| busy_o | output | 1 | A transaction is in progress |
| rd_data_o | output | 8 | Last byte read |
| cmd_vld_o | output | 1 | Command strobe to the byte engine |
| cmd_act_o | output | 2 | 00 none, 01 send, 10 receive |
| cmd_start_o | output | 1 | Precede the byte with a (repeated) START |
| cmd_stop_o | output | 1 | Follow with STOP |
| cmd_mnack_o | output | 1 | Master answers the received byte with not-acknowledge |
| cmd_data_o | output | 8 | Byte to send |
| cmd_done_i | input | 1 | Command completion pulse |
| cmd_nack_i | input | 1 | Slave did not acknowledge, valid with cmd_done_i |
| cmd_rd_data_i | input | 8 | Received byte, valid with cmd_done_i |

## Verification
The bench plays the byte engine and answers each command after a random delay. It injects a not-acknowledge on each send step of both transaction kinds. A design that skipped the STOP-only abort, or kept going after the failed byte, would produce a command list that does not match the expected one. Requests that arrive while busy carry different operands. A design that re-latched them would send wrong bytes, and one that accepted them would start a spurious transaction. Read data is checked after writes and aborts, which would expose a design that captures on any completion. The direction bit of the second address byte is also checked, which exposes a missing repeated START.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_SA_ISS,  S_SA_WT,
        S_RA_ISS,  S_RA_WT,
        S_WD_ISS,  S_WD_WT,
        S_RS_ISS,  S_RS_WT,
        S_RX_ISS,  S_RX_WT,
        S_AB_ISS,  S_AB_WT,
        S_FIN_OK,  S_FIN_ERR
    } seq_state_e;

    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_SEND = 2'b01,
        ACT_RECV = 2'b10
    } seq_act_e;

    typedef enum logic [2:0] {
        SRC_ZERO,
        SRC_SADDR_WR,
        SRC_SADDR_RD,
        SRC_REG,
        SRC_WDATA
    } byte_src_e;

    typedef struct packed {
        seq_act_e  act;
        logic      start;
        logic      stop;
        logic      mnack;
        logic      issue;
        byte_src_e src;
    } step_attr_t;

endpackage

// File: rtl/i2c_seq_fsm.sv
module i2c_seq_fsm
    import i2c_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic       rnw_q,
    input  logic       cmd_done_i,
    input  logic       cmd_nack_i,
    output seq_state_e state_o,
    output logic       accept_o,
    output logic       capture_o
);

    seq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (req_i) state_d = S_SA_ISS;
            S_SA_ISS:  state_d = S_SA_WT;
            S_SA_WT:   if (cmd_done_i) state_d = cmd_nack_i ? S_AB_ISS : S_RA_ISS;
            S_RA_ISS:  state_d = S_RA_WT;
            S_RA_WT:   if (cmd_done_i) state_d = cmd_nack_i ? S_AB_ISS
                                               : (rnw_q ? S_RS_ISS : S_WD_ISS);
            S_WD_ISS:  state_d = S_WD_WT;
            S_WD_WT:   if (cmd_done_i) state_d = cmd_nack_i ? S_AB_ISS : S_FIN_OK;
            S_RS_ISS:  state_d = S_RS_WT;
            S_RS_WT:   if (cmd_done_i) state_d = cmd_nack_i ? S_AB_ISS : S_RX_ISS;
            S_RX_ISS:  state_d = S_RX_WT;
            S_RX_WT:   if (cmd_done_i) state_d = S_FIN_OK;
            S_AB_ISS:  state_d = S_AB_WT;
            S_AB_WT:   if (cmd_done_i) state_d = S_FIN_ERR;
            S_FIN_OK:  state_d = S_IDLE;
            S_FIN_ERR: state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    assign state_o   = state_q;
    assign accept_o  = (state_q == S_IDLE) && req_i;
    assign capture_o = (state_q == S_RX_WT) && cmd_done_i;

endmodule

// File: rtl/i2c_seq_decode.sv
module i2c_seq_decode
    import i2c_seq_pkg::*;
(
    input  seq_state_e state_i,
    output step_attr_t attr_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       err_o
);

    always_comb begin
        attr_o = '{act: ACT_NONE, start: 1'b0, stop: 1'b0, mnack: 1'b0,
                   issue: 1'b0, src: SRC_ZERO};
        unique case (state_i)
            S_SA_ISS, S_SA_WT: begin
                attr_o.act   = ACT_SEND;
                attr_o.start = 1'b1;
                attr_o.src   = SRC_SADDR_WR;
            end
            S_RA_ISS, S_RA_WT: begin
                attr_o.act = ACT_SEND;
                attr_o.src = SRC_REG;
            end
            S_WD_ISS, S_WD_WT: begin
                attr_o.act  = ACT_SEND;
                attr_o.stop = 1'b1;
                attr_o.src  = SRC_WDATA;
            end
            S_RS_ISS, S_RS_WT: begin
                attr_o.act   = ACT_SEND;
                attr_o.start = 1'b1;
                attr_o.src   = SRC_SADDR_RD;
            end
            S_RX_ISS, S_RX_WT: begin
                attr_o.act   = ACT_RECV;
                attr_o.stop  = 1'b1;
                attr_o.mnack = 1'b1;
            end
            S_AB_ISS, S_AB_WT: begin
                attr_o.stop = 1'b1;
            end
            S_IDLE, S_FIN_OK, S_FIN_ERR: ;
            default: ;
        endcase
        attr_o.issue = (state_i == S_SA_ISS) || (state_i == S_RA_ISS) ||
                       (state_i == S_WD_ISS) || (state_i == S_RS_ISS) ||
                       (state_i == S_RX_ISS) || (state_i == S_AB_ISS);
    end

    assign busy_o = (state_i != S_IDLE);
    assign done_o = (state_i == S_FIN_OK) || (state_i == S_FIN_ERR);
    assign err_o  = (state_i == S_FIN_ERR);

endmodule

// File: rtl/i2c_seq_operands.sv
module i2c_seq_operands
    import i2c_seq_pkg::*;
#(
    parameter int SADDR_W = 7,
    localparam int BYTE_W = SADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic              capture_i,
    input  logic              rnw_i,
    input  logic [SADDR_W-1:0] slv_addr_i,
    input  logic [BYTE_W-1:0] reg_addr_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic [BYTE_W-1:0] rx_byte_i,
    input  byte_src_e         src_i,
    output logic              rnw_q,
    output logic [BYTE_W-1:0] cmd_byte_o,
    output logic [BYTE_W-1:0] rd_data_o
);

    logic [SADDR_W-1:0] slv_q;
    logic [BYTE_W-1:0]  reg_q, wd_q, rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rnw_q <= 1'b0;
            slv_q <= '0;
            reg_q <= '0;
            wd_q  <= '0;
        end else if (accept_i) begin
            rnw_q <= rnw_i;
            slv_q <= slv_addr_i;
            reg_q <= reg_addr_i;
            wd_q  <= wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         rd_q <= '0;
        else if (capture_i) rd_q <= rx_byte_i;
    end

    always_comb begin
        unique case (src_i)
            SRC_SADDR_WR: cmd_byte_o = {slv_q, 1'b0};
            SRC_SADDR_RD: cmd_byte_o = {slv_q, 1'b1};
            SRC_REG:      cmd_byte_o = reg_q;
            SRC_WDATA:    cmd_byte_o = wd_q;
            default:      cmd_byte_o = '0;
        endcase
    end

    assign rd_data_o = rd_q;

endmodule

// File: rtl/i2c_reg_seq.sv
module i2c_reg_seq
    import i2c_seq_pkg::*;
#(
    parameter int SADDR_W = 7,
    localparam int BYTE_W = SADDR_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_i,
    input  logic               rnw_i,
    input  logic [SADDR_W-1:0] slv_addr_i,
    input  logic [BYTE_W-1:0]  reg_addr_i,
    input  logic [BYTE_W-1:0]  wr_data_i,
    output logic               done_o,
    output logic               err_o,
    output logic               busy_o,
    output logic [BYTE_W-1:0]  rd_data_o,
    output logic               cmd_vld_o,
    output logic [1:0]         cmd_act_o,
    output logic               cmd_start_o,
    output logic               cmd_stop_o,
    output logic               cmd_mnack_o,
    output logic [BYTE_W-1:0]  cmd_data_o,
    input  logic               cmd_done_i,
    input  logic               cmd_nack_i,
    input  logic [BYTE_W-1:0]  cmd_rd_data_i
);

    seq_state_e state;
    step_attr_t attr;
    logic       accept, capture, rnw_q;

    i2c_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .rnw_q     (rnw_q),
        .cmd_done_i(cmd_done_i),
        .cmd_nack_i(cmd_nack_i),
        .state_o   (state),
        .accept_o  (accept),
        .capture_o (capture)
    );

    i2c_seq_decode u_dec (
        .state_i(state),
        .attr_o (attr),
        .busy_o (busy_o),
        .done_o (done_o),
        .err_o  (err_o)
    );

    i2c_seq_operands #(.SADDR_W(SADDR_W)) u_ops (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_i  (accept),
        .capture_i (capture),
        .rnw_i     (rnw_i),
        .slv_addr_i(slv_addr_i),
        .reg_addr_i(reg_addr_i),
        .wr_data_i (wr_data_i),
        .rx_byte_i (cmd_rd_data_i),
        .src_i     (attr.src),
        .rnw_q     (rnw_q),
        .cmd_byte_o(cmd_data_o),
        .rd_data_o (rd_data_o)
    );

    assign cmd_vld_o   = attr.issue;
    assign cmd_act_o   = attr.act;
    assign cmd_start_o = attr.start;
    assign cmd_stop_o  = attr.stop;
    assign cmd_mnack_o = attr.mnack;

endmodule

// File: rtl/i2c_reg_seq_chk.sv
module i2c_reg_seq_chk #(
    parameter int SADDR_W = 7,
    localparam int BYTE_W = SADDR_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_i,
    input logic              done_o,
    input logic              err_o,
    input logic              busy_o,
    input logic [BYTE_W-1:0] rd_data_o,
    input logic              cmd_vld_o,
    input logic [1:0]        cmd_act_o,
    input logic              cmd_start_o,
    input logic              cmd_stop_o,
    input logic              cmd_mnack_o,
    input logic [BYTE_W-1:0] cmd_data_o,
    input logic              cmd_done_i
);

    logic pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         pend <= 1'b0;
        else if (cmd_vld_o) pend <= 1'b1;
        else if (cmd_done_i) pend <= 1'b0;
    end

    a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld_o |-> !pend);

    a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld_o |=> !cmd_vld_o);

    a_r3_mnack_on_recv: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld_o |-> (cmd_mnack_o == (cmd_act_o == 2'b10)));

    a_r5_abort_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld_o && cmd_act_o == 2'b00) |-> (cmd_stop_o && !cmd_start_o));

    a_r6_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);

    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r7_busy_covers_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    a_r7_busy_from_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(req_i));

    a_r9_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && cmd_done_i && cmd_act_o == 2'b10) |=> $stable(rd_data_o));

    a_r10_hold_while_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !cmd_done_i && !cmd_vld_o) |=>
            $stable({cmd_act_o, cmd_start_o, cmd_stop_o, cmd_mnack_o, cmd_data_o}));

endmodule

bind i2c_reg_seq i2c_reg_seq_chk #(.SADDR_W(SADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .done_o     (done_o),
    .err_o      (err_o),
    .busy_o     (busy_o),
    .rd_data_o  (rd_data_o),
    .cmd_vld_o  (cmd_vld_o),
    .cmd_act_o  (cmd_act_o),
    .cmd_start_o(cmd_start_o),
    .cmd_stop_o (cmd_stop_o),
    .cmd_mnack_o(cmd_mnack_o),
    .cmd_data_o (cmd_data_o),
    .cmd_done_i (cmd_done_i)
);

// File: tb/i2c_reg_seq_tb_top.sv
module i2c_reg_seq_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_i = 1'b0;
    logic       rnw_i = 1'b0;
    logic [6:0] slv_addr_i = '0;
    logic [7:0] reg_addr_i = '0;
    logic [7:0] wr_data_i = '0;
    logic       done_o, err_o, busy_o;
    logic [7:0] rd_data_o;
    logic       cmd_vld_o;
    logic [1:0] cmd_act_o;
    logic       cmd_start_o, cmd_stop_o, cmd_mnack_o;
    logic [7:0] cmd_data_o;
    logic       cmd_done_i = 1'b0;
    logic       cmd_nack_i = 1'b0;
    logic [7:0] cmd_rd_data_i = '0;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;
    logic [7:0] last_rd = 8'h00;

    always #(CLK_PERIOD / 2) clk = ~clk;

    i2c_reg_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .rnw_i(rnw_i),
        .slv_addr_i(slv_addr_i), .reg_addr_i(reg_addr_i), .wr_data_i(wr_data_i),
        .done_o(done_o), .err_o(err_o), .busy_o(busy_o), .rd_data_o(rd_data_o),
        .cmd_vld_o(cmd_vld_o), .cmd_act_o(cmd_act_o), .cmd_start_o(cmd_start_o),
        .cmd_stop_o(cmd_stop_o), .cmd_mnack_o(cmd_mnack_o), .cmd_data_o(cmd_data_o),
        .cmd_done_i(cmd_done_i), .cmd_nack_i(cmd_nack_i), .cmd_rd_data_i(cmd_rd_data_i)
    );

    function automatic logic [12:0] cword(logic [1:0] act, logic st, logic sp,
                                          logic mn, logic [7:0] d);
        return {act, st, sp, mn, (act == 2'b01) ? d : 8'h00};
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic run_txn(input bit rnw, input logic [6:0] sa, input logic [7:0] ra,
                           input logic [7:0] wd, input int nack_step,
                           input logic [7:0] rx, input bit inject);
        logic [12:0] e[8];
        logic [12:0] g[8];
        int ne = 0;
        int n = 0;
        int cd = 0;
        bit pending = 0;
        bit seen = 0;
        bit mism = 0;
        logic got_err = 1'b0;
        logic [7:0] got_rd = 8'h00;
        logic [7:0] exp_rd;
        // expected command list (R2 write, R3 read, R5 abort)
        e[ne] = cword(2'b01, 1, 0, 0, {sa, 1'b0}); ne++;
        if (nack_step != 1) begin
            e[ne] = cword(2'b01, 0, 0, 0, ra); ne++;
            if (nack_step != 2) begin
                if (!rnw) begin
                    e[ne] = cword(2'b01, 0, 1, 0, wd); ne++;
                end else begin
                    e[ne] = cword(2'b01, 1, 0, 0, {sa, 1'b1}); ne++;
                    if (nack_step != 3) begin
                        e[ne] = cword(2'b10, 0, 1, 1, 8'h00); ne++;
                    end
                end
            end
        end
        if (nack_step != 0) begin
            e[ne] = cword(2'b00, 0, 1, 0, 8'h00); ne++;
        end
        exp_rd = (rnw && nack_step == 0) ? rx : last_rd;

        @(negedge clk);
        req_i = 1'b1; rnw_i = rnw; slv_addr_i = sa; reg_addr_i = ra; wr_data_i = wd;
        @(negedge clk);
        req_i = 1'b0;
        check("R7 busy after accept", busy_o, 1);
        for (int cyc = 0; cyc < 200 && !seen; cyc++) begin
            if (cyc > 0) @(negedge clk);
            cmd_done_i = 1'b0;
            cmd_nack_i = 1'b0;
            if (inject) begin
                req_i = 1'($urandom_range(0, 1));
                rnw_i = 1'($urandom);
                slv_addr_i = 7'($urandom);
                reg_addr_i = 8'($urandom);
                wr_data_i = 8'($urandom);
            end
            if (done_o) begin
                seen = 1;
                req_i = 1'b0;
                got_err = err_o;
                got_rd = rd_data_o;
            end else if (cmd_vld_o) begin
                if (n < 8) g[n] = cword(cmd_act_o, cmd_start_o, cmd_stop_o, cmd_mnack_o, cmd_data_o);
                n++;
                pending = 1;
                cd = $urandom_range(0, 3);
            end else if (pending) begin
                if (cd == 0) begin
                    cmd_done_i = 1'b1;
                    cmd_nack_i = (n == nack_step);
                    cmd_rd_data_i = rx;
                    pending = 0;
                end else begin
                    cd--;
                end
            end
        end
        req_i = 1'b0;
        check("R6 done seen", seen, 1);
        check(rnw ? "R3 command count" : "R2 command count", n, ne);
        for (int i = 0; i < ne && i < n && i < 8; i++)
            if (g[i] !== e[i]) mism = 1;
        if (mism)
            for (int i = 0; i < ne && i < n && i < 8; i++)
                check(rnw ? "R3 command word" : "R2 command word", g[i], e[i]);
        else
            check(rnw ? "R3 command list" : "R2 command list", 0, 0);
        check("R5 error flag", got_err, (nack_step != 0));
        check("R9 read data", got_rd, exp_rd);
        last_rd = exp_rd;
        @(negedge clk);
        check("R6 done one cycle", done_o, 0);
        check("R7 busy low after done", busy_o, 0);
        if (inject) begin
            for (int k = 0; k < 3; k++) begin
                check("R8 no new transaction", {busy_o, cmd_vld_o}, 0);
                @(negedge clk);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd7301));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 idle after reset",
              {busy_o, done_o, err_o, cmd_vld_o, rd_data_o}, 12'h000);
        // directed: plain write, plain read, aborts on each send step
        run_txn(0, 7'h50, 8'h10, 8'hA5, 0, 8'h00, 0);
        run_txn(1, 7'h50, 8'h11, 8'h00, 0, 8'h3C, 0);
        run_txn(0, 7'h7F, 8'hFF, 8'h5A, 0, 8'hEE, 0); // R9 write keeps read byte
        run_txn(0, 7'h21, 8'h02, 8'h33, 1, 8'h00, 0); // R5 step 1
        run_txn(0, 7'h21, 8'h02, 8'h33, 2, 8'h00, 0); // R5 step 2
        run_txn(0, 7'h21, 8'h02, 8'h33, 3, 8'h00, 0); // R5 step 3
        run_txn(1, 7'h00, 8'h00, 8'h00, 3, 8'h99, 0); // R5 repeated-start NACK
        run_txn(1, 7'h01, 8'h80, 8'h00, 0, 8'hC3, 1); // R8 requests while busy
        run_txn(0, 7'h44, 8'h55, 8'h66, 0, 8'h00, 1); // R8 R10
        for (int t = 0; t < 150; t++) begin
            int ns;
            ns = ($urandom_range(0, 9) < 7) ? 0 : $urandom_range(1, 3);
            run_txn(1'($urandom), 7'($urandom), 8'($urandom), 8'($urandom), ns,
                    8'($urandom), 1'($urandom_range(0, 3) == 0));
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule